// File: doc/BRIEF.md
# Receive Clock Lock Monitor

The block decides whether a line receiver is running from its local reference clock or from the clock recovered from the line. It counts recovered-clock edges over a fixed span of reference-clock cycles. When the count is close to the span length, the two frequencies agree and the receiver is treated as locked to the line. In that case the block clears its loss-of-lock flag and selects the recovered clock as the receive clock source. When the relative difference reaches about half a percent, the block reports loss of lock and selects the reference clock. This is the training state.

Each measurement span is started from the reference domain, and the recovered-domain count comes back through a toggle request/acknowledge pair with two-flop synchronizers. A verdict moves the state only after a configurable number of consecutive spans all disagree with the current state. A slow drift near the threshold therefore cannot make the flag chatter. The clock multiplexer is outside the block; the block supplies a registered select for it.

Top module: `rx_lock_monitor`

## Requirements
- R1: While `rst_n` is low, and right after it is released, `loss_of_lock` is 1 and `rec_clk_sel` is 0.
- R2: A span lasts 2^WIN_LOG2 reference cycles. A span whose recovered-edge count differs from 2^WIN_LOG2 by THRESH or more is a bad span. The defaults are 4096 and 21, which is about 0.5 %.
- R3: A span whose count differs from 2^WIN_LOG2 by less than THRESH is a good span.
- R4: The state changes only after AGREE consecutive spans (default 2) all disagree with it. A single disagreeing span, followed by an agreeing one, leaves the outputs unchanged.
- R5: `loss_of_lock` is 1 in the training state and 0 in the recovery state.
- R6: `rec_clk_sel` is 1 to select the recovered clock and 0 to select the reference clock. It is always the inverse of `loss_of_lock`.
- R7: If a span ends while the previous measurement has not come back (for example, the recovered clock has stopped), that span counts as bad.
- R8: The first measurement after reset is discarded. With a matching recovered clock, lock therefore appears after the third span ends and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Local reference clock; measurement spans and outputs live here |
| rec_clk | input | 1 | Clock recovered from the line |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously in each domain |
| loss_of_lock | output | 1 | 1 in training state, 0 when locked to the line |
| rec_clk_sel | output | 1 | Receive clock source select: 1 recovered, 0 reference |

## Verification
The assertions check four things on every reference cycle: the select stays the complement of the flag, the flag matches the internal state, the state never changes without a full streak of disagreeing verdicts, and the handshake never issues a request while one is outstanding. The bench scenarios cover the behaviour the assertions cannot. They sweep recovered-clock periods on both sides of the threshold, with the expected verdict computed from the period ratio. They also cover the latency to first lock after reset, a stopped recovered clock, and a short dropout that upsets at most one span without moving the outputs.

// File: rtl/lock_mon_pkg.sv
package lock_mon_pkg;

  typedef enum logic {
    MODE_TRAIN = 1'b0,
    MODE_RECOV = 1'b1
  } lock_mode_e;

  function automatic int unsigned abs_gap(input int unsigned a, input int unsigned b);
    return (a >= b) ? (a - b) : (b - a);
  endfunction

endpackage

// File: rtl/lock_sync.sv
module lock_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg1_q;
  logic [W-1:0] stg2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg1_q <= '0;
      stg2_q <= '0;
    end else begin
      stg1_q <= d;
      stg2_q <= stg1_q;
    end
  end

  assign q = stg2_q;
endmodule

// File: rtl/lock_rec_counter.sv
module lock_rec_counter #(
  parameter int CW = 14
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_s,
  output logic          ack_tgl,
  output logic [CW-1:0] hold
);
  localparam logic [CW-1:0] CNT_MAX = {CW{1'b1}};

  logic          req_d_q;
  logic          cap;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] hold_q, hold_d;
  logic          ack_q, ack_d;

  assign cap = req_s ^ req_d_q;

  always_comb begin
    cnt_d  = cnt_q;
    hold_d = hold_q;
    ack_d  = ack_q;
    if (cap) begin
      hold_d = cnt_q;
      cnt_d  = {{(CW-1){1'b0}}, 1'b1};
      ack_d  = ~ack_q;
    end else if (cnt_q != CNT_MAX) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_d_q <= 1'b0;
      cnt_q   <= '0;
      hold_q  <= '0;
      ack_q   <= 1'b0;
    end else begin
      req_d_q <= req_s;
      cnt_q   <= cnt_d;
      hold_q  <= hold_d;
      ack_q   <= ack_d;
    end
  end

  assign ack_tgl = ack_q;
  assign hold    = hold_q;

  // R2: the count handed across only moves when an acknowledge toggles with it
  a_r2_hold_with_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_q != $past(hold_q)) |-> (ack_q != $past(ack_q)));
endmodule

// File: rtl/lock_window_ctrl.sv
module lock_window_ctrl
  import lock_mon_pkg::*;
#(
  parameter int WIN_LOG2 = 12,
  parameter int CW       = WIN_LOG2 + 2,
  parameter int THRESH   = 21
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ack_s,
  input  logic [CW-1:0] hold_in,
  output logic          req_tgl,
  output logic          vld,
  output logic          bad
);
  localparam int unsigned WIN = 1 << WIN_LOG2;

  logic [WIN_LOG2-1:0] win_q, win_d;
  logic                win_end;
  logic                ack_d_q;
  logic                ack_edge;
  logic                pend_q, pend_d;
  logic                primed_q, primed_d;
  logic                req_q, req_d;
  logic                vld_q, vld_d;
  logic                bad_q, bad_d;
  logic                over;

  assign win_end  = (win_q == {WIN_LOG2{1'b1}});
  assign ack_edge = ack_s ^ ack_d_q;
  assign over     = abs_gap(int'(hold_in), WIN) >= THRESH;

  always_comb begin
    win_d    = win_q + 1'b1;
    pend_d   = pend_q;
    primed_d = primed_q;
    req_d    = req_q;
    vld_d    = 1'b0;
    bad_d    = bad_q;
    if (ack_edge) begin
      pend_d   = 1'b0;
      primed_d = 1'b1;
      if (primed_q) begin
        vld_d = 1'b1;
        bad_d = over;
      end
    end
    if (win_end) begin
      if (pend_q && !ack_edge) begin
        vld_d = 1'b1;
        bad_d = 1'b1;
      end else begin
        req_d  = ~req_q;
        pend_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q    <= '0;
      ack_d_q  <= 1'b0;
      pend_q   <= 1'b0;
      primed_q <= 1'b0;
      req_q    <= 1'b0;
      vld_q    <= 1'b0;
      bad_q    <= 1'b1;
    end else begin
      win_q    <= win_d;
      ack_d_q  <= ack_s;
      pend_q   <= pend_d;
      primed_q <= primed_d;
      req_q    <= req_d;
      vld_q    <= vld_d;
      bad_q    <= bad_d;
    end
  end

  assign req_tgl = req_q;
  assign vld     = vld_q;
  assign bad     = bad_q;

  // R7: a new request is never issued while one is still outstanding
  a_r7_req_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (req_q != $past(req_q)) |-> (!$past(pend_q) || $past(ack_edge)));
  // R8: acknowledges only arrive for outstanding requests
  a_r8_ack_expected: assert property (@(posedge clk) disable iff (!rst_n)
    ack_edge |-> pend_q);
endmodule

// File: rtl/lock_hyst.sv
module lock_hyst
  import lock_mon_pkg::*;
#(
  parameter int AGREE = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic vld,
  input  logic bad,
  output logic lol,
  output logic sel_rec
);
  localparam int SW = $clog2(AGREE) + 1;
  localparam logic [SW-1:0] LAST = SW'(AGREE - 1);

  lock_mode_e   mode_q, mode_d;
  logic [SW-1:0] streak_q, streak_d;
  logic          lol_q, sel_q;
  logic          differ;

  assign differ = vld && (bad == (mode_q == MODE_RECOV));

  always_comb begin
    mode_d   = mode_q;
    streak_d = streak_q;
    if (vld) begin
      if (!differ) begin
        streak_d = '0;
      end else if (streak_q == LAST) begin
        streak_d = '0;
        mode_d   = (mode_q == MODE_TRAIN) ? MODE_RECOV : MODE_TRAIN;
      end else begin
        streak_d = streak_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= MODE_TRAIN;
      streak_q <= '0;
      lol_q    <= 1'b1;
      sel_q    <= 1'b0;
    end else begin
      mode_q   <= mode_d;
      streak_q <= streak_d;
      lol_q    <= (mode_d == MODE_TRAIN);
      sel_q    <= (mode_d == MODE_RECOV);
    end
  end

  assign lol     = lol_q;
  assign sel_rec = sel_q;

  // R4: a state change only follows a full streak of disagreeing verdicts
  a_r4_streak_before_flip: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q != $past(mode_q)) |-> ($past(differ) && $past(streak_q) == LAST));
  a_r4_streak_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    streak_q <= LAST);
  // R5: the flag follows the state
  a_r5_flag_matches_mode: assert property (@(posedge clk) disable iff (!rst_n)
    lol_q == (mode_q == MODE_TRAIN));
  // R6: the select is always the inverse of the flag
  a_r6_sel_inverse: assert property (@(posedge clk) disable iff (!rst_n)
    sel_q == !lol_q);
endmodule

// File: rtl/rx_lock_monitor.sv
module rx_lock_monitor #(
  parameter int WIN_LOG2 = 12,
  parameter int THRESH   = 21,
  parameter int AGREE    = 2
) (
  input  logic ref_clk,
  input  logic rec_clk,
  input  logic rst_n,
  output logic loss_of_lock,
  output logic rec_clk_sel
);
  localparam int CW = WIN_LOG2 + 2;

  logic          ref_rst_n, rec_rst_n;
  logic          req_tgl, req_s;
  logic          ack_tgl, ack_s;
  logic [CW-1:0] hold;
  logic          vld, bad;

  lock_sync #(.W(1)) u_ref_rst (
    .clk(ref_clk), .rst_n(rst_n), .d(1'b1), .q(ref_rst_n));
  lock_sync #(.W(1)) u_rec_rst (
    .clk(rec_clk), .rst_n(rst_n), .d(1'b1), .q(rec_rst_n));

  lock_sync #(.W(1)) u_req_sync (
    .clk(rec_clk), .rst_n(rec_rst_n), .d(req_tgl), .q(req_s));
  lock_sync #(.W(1)) u_ack_sync (
    .clk(ref_clk), .rst_n(ref_rst_n), .d(ack_tgl), .q(ack_s));

  lock_rec_counter #(.CW(CW)) u_rec_cnt (
    .clk(rec_clk), .rst_n(rec_rst_n), .req_s(req_s),
    .ack_tgl(ack_tgl), .hold(hold));

  lock_window_ctrl #(.WIN_LOG2(WIN_LOG2), .CW(CW), .THRESH(THRESH)) u_win (
    .clk(ref_clk), .rst_n(ref_rst_n), .ack_s(ack_s), .hold_in(hold),
    .req_tgl(req_tgl), .vld(vld), .bad(bad));

  lock_hyst #(.AGREE(AGREE)) u_hyst (
    .clk(ref_clk), .rst_n(ref_rst_n), .vld(vld), .bad(bad),
    .lol(loss_of_lock), .sel_rec(rec_clk_sel));
endmodule

// File: tb/rx_lock_monitor_tb.sv
`timescale 1ns/1ps
module rx_lock_monitor_tb;
  localparam int WIN_LOG2 = 10;
  localparam int WIN      = 1 << WIN_LOG2;
  localparam int THRESH   = 6;

  logic ref_clk = 1'b0;
  logic rec_clk = 1'b0;
  logic rst_n   = 1'b0;
  logic loss_of_lock, rec_clk_sel;

  int   n_checks = 0;
  int   n_errors = 0;
  int   rec_period_ps = 10000;
  bit   rec_stop = 1'b0;

  rx_lock_monitor #(.WIN_LOG2(WIN_LOG2), .THRESH(THRESH), .AGREE(2)) u_dut (
    .ref_clk(ref_clk), .rec_clk(rec_clk), .rst_n(rst_n),
    .loss_of_lock(loss_of_lock), .rec_clk_sel(rec_clk_sel));

  always #5 ref_clk = ~ref_clk;

  always begin
    if (rec_stop) #1;
    else begin
      #(rec_period_ps / 2000.0);
      rec_clk = ~rec_clk;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_outs(input string req, input bit exp_lol);
    check(loss_of_lock == exp_lol, req, int'(loss_of_lock), int'(exp_lol));
    check(rec_clk_sel == !exp_lol, {req, "/R6"}, int'(rec_clk_sel), int'(!exp_lol));
  endtask

  task automatic wait_ref(input int n);
    repeat (n) @(negedge ref_clk);
  endtask

  function automatic bit expect_bad(input int p_ps);
    int cnt = (WIN * 10000) / p_ps;
    int gap = (cnt > WIN) ? cnt - WIN : WIN - cnt;
    return gap >= THRESH;
  endfunction

  initial begin : main
    int periods[10] = '{10000, 10030, 10100, 9960, 9900, 10040, 12000, 10000, 8000, 9000};
    int hi_cycles;
    wait_ref(3);
    check_outs("R1 in reset", 1'b1);
    rst_n = 1'b1;
    wait_ref(1);
    check_outs("R1 after release", 1'b1);
    // R8: first result discarded, so no lock before the third span ends
    wait_ref(WIN * 2 + WIN / 2);
    check_outs("R8 no early lock", 1'b1);
    wait_ref(WIN);
    check_outs("R4 R5 lock after two good spans", 1'b0);

    // R2 R3: sweep periods on both sides of the threshold
    foreach (periods[i]) begin
      bit eb;
      rec_period_ps = periods[i];
      eb = expect_bad(periods[i]);
      wait_ref(WIN * 6);
      check_outs(eb ? "R2 bad span sweep" : "R3 good span sweep", eb);
    end

    // R7: stopped recovered clock
    rec_period_ps = 10000;
    wait_ref(WIN * 6);
    check_outs("R3 relock before stop", 1'b0);
    rec_stop = 1'b1;
    wait_ref(WIN * 5);
    check_outs("R7 stopped clock", 1'b1);
    rec_stop = 1'b0;
    wait_ref(WIN * 7);
    check_outs("R7 relock after restart", 1'b0);

    // R4: a short dropout upsets at most one span; outputs must not move
    #3.3;
    rec_stop = 1'b1;
    #80;
    rec_stop = 1'b0;
    hi_cycles = 0;
    for (int k = 0; k < WIN * 4; k++) begin
      @(negedge ref_clk);
      if (loss_of_lock || !rec_clk_sel) hi_cycles++;
    end
    check(hi_cycles == 0, "R4 single bad span ignored", hi_cycles, 0);

    // R1: reset while locked
    @(negedge ref_clk);
    rst_n = 1'b0;
    #1;
    check_outs("R1 reset while locked", 1'b1);
    wait_ref(3);
    rst_n = 1'b1;
    wait_ref(WIN * 4);
    check_outs("R4 lock again after reset", 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin : watchdog
    repeat (200000) @(posedge ref_clk);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule